// File: doc/BRIEF.md
# Sectioned Bit De-interleaver Buffer

This block sits between a soft-decision demapper and the inner decoder of a multicarrier receiver. The cells it receives are already in de-interleaved cell order. Each cell carries up to six soft values, one per bit stream, and each soft value is 6 bits wide (64 levels). The block writes the cells into a single section store that holds 126 cells. When the store is full, the block drops its input ready, so the upstream stages stall. It then sends the section out, one soft value per beat, reading each bit stream at its own cyclic offset.

The number of active bit streams depends on a two-bit constellation code. The block samples this code together with the first cell of each section. Because there is only one store, the block accepts no new cell until the last soft value of the section has left. Output valid and ready follow the usual rule: a value leaves only in a cycle where both are high.

Top module: `bdi_section_buffer`

## Requirements
- R1: After reset, `in_ready` is high and `out_valid` is low.
- R2: While a section is filling, `in_ready` is high. From the cycle after the 126th cell is accepted until the section has fully drained, `in_ready` is low and `out_valid` is high. The two are never high in the same cycle.
- R3: A section drains in exactly 126·n beats. The stream count n comes from the constellation code: 0 gives 2, 1 gives 4, and 2 or 3 gives 6.
- R4: Beats are ordered by output index w from 0 to 125. Within each w, the active streams e run from 0 to n−1. The value for stream e is bits [6e+5:6e] of the cell written at position (w + s_e) mod 126, counting positions from 0 in arrival order, where s = 0, 63, 105, 42, 21, 84 for e = 0 to 5. Cell bits above 6n are never output.
- R5: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with `out_soft` unchanged. No value is lost or repeated.
- R6: The constellation code is taken only in the cycle that accepts the first cell of a section. Any change to it during the rest of the section has no effect on that section's output.
- R7: In the cycle after the last beat of a section is accepted, `in_ready` is high again and the next accepted cell becomes position 0 of a new section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input cell present |
| in_ready | output | 1 | Block can take a cell (section filling) |
| in_cell | input | 36 | Soft values of one cell; stream e in bits [6e+5:6e] |
| in_mode | input | 2 | Constellation code (0: 2 streams, 1: 4, 2/3: 6) |
| out_valid | output | 1 | Soft value present (section draining) |
| out_ready | input | 1 | Downstream takes the value |
| out_soft | output | 6 | One soft value |

## Verification
Every section is filled with random 36-bit cells. Because each stream reads at a different cyclic offset, a wrong shift, a wrong lane slice or a wrong wrap point shows up as a mismatch with the bench's own model. The bench runs sections in all four constellation codes. The 2/4/6 codes separate errors in stream count and lane order, and code 3 checks that it is treated like code 2. Within each section the code input is changed after the first cell, so a block that samples the code at the wrong time drains the wrong number of beats. Gaps in valid and random downstream ready separate correct hold behaviour from lost or repeated values. Input held high during the drain shows whether the stall really blocks writes.

// File: rtl/bdi_pkg.sv
package bdi_pkg;

    localparam int SOFT_W        = 6;
    localparam int MAX_STREAMS   = 6;
    localparam int SECTION_CELLS = 126;
    localparam int MODE_W        = 2;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    // Active bit streams for a constellation code.
    function automatic int streams_of(logic [MODE_W-1:0] mode);
        case (mode)
            2'd0:    return 2;
            2'd1:    return 4;
            default: return 6;
        endcase
    endfunction

    // Cyclic read offset of bit stream 'lane' within a section of 'cells'.
    function automatic int shift_of(int lane, int cells);
        case (lane)
            0:       return 0;
            1:       return cells / 2;
            2:       return (5 * cells) / 6;
            3:       return cells / 3;
            4:       return cells / 6;
            default: return (2 * cells) / 3;
        endcase
    endfunction

endpackage

// File: rtl/bdi_section_mem.sv
module bdi_section_mem #(
    parameter int CELLS  = 126,
    parameter int CELL_W = 36,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [CELL_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [CELL_W-1:0] rd_data
);

    logic [CELL_W-1:0] store_q [CELLS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/bdi_read_seq.sv
module bdi_read_seq
    import bdi_pkg::*;
#(
    parameter int CELLS       = 126,
    parameter int STREAMS_MAX = 6,
    localparam int IDX_W      = $clog2(CELLS),
    localparam int LANE_W     = $clog2(STREAMS_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [LANE_W:0]   nstreams,
    output logic [IDX_W-1:0]  rd_addr,
    output logic [LANE_W-1:0] lane,
    output logic              last_beat
);

    typedef logic [IDX_W:0] sum_t;

    typedef struct packed {
        logic [IDX_W-1:0]  w;
        logic [LANE_W-1:0] e;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_lane;
    sum_t sum;

    always_comb begin
        seq_d     = seq_q;
        last_lane = (int'(seq_q.e) == int'(nstreams) - 1);
        last_beat = last_lane && (int'(seq_q.w) == CELLS - 1);

        if (step) begin
            if (last_lane) begin
                seq_d.e = '0;
                seq_d.w = (int'(seq_q.w) == CELLS - 1) ? '0 : seq_q.w + 1'b1;
            end else begin
                seq_d.e = seq_q.e + 1'b1;
            end
        end

        sum = sum_t'(seq_q.w) + sum_t'(shift_of(int'(seq_q.e), CELLS));
        if (sum >= sum_t'(CELLS)) begin
            sum = sum - sum_t'(CELLS);
        end
        rd_addr = sum[IDX_W-1:0];
        lane    = seq_q.e;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/bdi_section_buffer.sv
module bdi_section_buffer
    import bdi_pkg::*;
#(
    parameter int CELLS       = SECTION_CELLS,
    parameter int STREAMS_MAX = MAX_STREAMS,
    parameter int SW          = SOFT_W,
    localparam int CELL_W     = STREAMS_MAX * SW,
    localparam int IDX_W      = $clog2(CELLS),
    localparam int LANE_W     = $clog2(STREAMS_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CELL_W-1:0] in_cell,
    input  logic [MODE_W-1:0] in_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SW-1:0]     out_soft
);

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  wr_idx;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic              fill_fire;
    logic              drain_fire;
    logic              last_beat;
    logic [IDX_W-1:0]  rd_addr;
    logic [LANE_W-1:0] lane;
    logic [LANE_W:0]   nstreams;
    logic [CELL_W-1:0] rd_cell;
    logic [SW-1:0]     lane_val [STREAMS_MAX];

    assign in_ready   = (ctl_q.phase == PH_FILL);
    assign out_valid  = (ctl_q.phase == PH_DRAIN);
    assign fill_fire  = in_valid && in_ready;
    assign drain_fire = out_valid && out_ready;
    assign nstreams   = (LANE_W + 1)'(streams_of(ctl_q.mode));

    always_comb begin
        ctl_d = ctl_q;
        if (fill_fire) begin
            if (ctl_q.wr_idx == '0) begin
                ctl_d.mode = in_mode;
            end
            if (int'(ctl_q.wr_idx) == CELLS - 1) begin
                ctl_d.wr_idx = '0;
                ctl_d.phase  = PH_DRAIN;
            end else begin
                ctl_d.wr_idx = ctl_q.wr_idx + 1'b1;
            end
        end
        if (drain_fire && last_beat) begin
            ctl_d.phase = PH_FILL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_FILL, wr_idx: '0, mode: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bdi_section_mem #(
        .CELLS  (CELLS),
        .CELL_W (CELL_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (fill_fire),
        .wr_addr (ctl_q.wr_idx),
        .wr_data (in_cell),
        .rd_addr (rd_addr),
        .rd_data (rd_cell)
    );

    bdi_read_seq #(
        .CELLS       (CELLS),
        .STREAMS_MAX (STREAMS_MAX)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (drain_fire),
        .nstreams  (nstreams),
        .rd_addr   (rd_addr),
        .lane      (lane),
        .last_beat (last_beat)
    );

    for (genvar g = 0; g < STREAMS_MAX; g++) begin : g_lane
        assign lane_val[g] = rd_cell[g*SW +: SW];
    end

    assign out_soft = lane_val[lane];

endmodule

// File: rtl/bdi_checker.sv
module bdi_checker #(
    parameter int CELLS       = 126,
    parameter int STREAMS_MAX = 6,
    parameter int SW          = 6,
    localparam int CNT_W      = $clog2(CELLS * STREAMS_MAX + 1) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [SW-1:0] out_soft
);

    logic [CNT_W-1:0] fill_cnt_q;
    logic [CNT_W-1:0] beat_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt_q <= '0;
            beat_cnt_q <= '0;
        end else begin
            if (out_valid) begin
                fill_cnt_q <= '0;
            end else if (in_valid && in_ready) begin
                fill_cnt_q <= fill_cnt_q + 1'b1;
            end
            if (!out_valid) begin
                beat_cnt_q <= '0;
            end else if (out_ready) begin
                beat_cnt_q <= beat_cnt_q + 1'b1;
            end
        end
    end

    // R2: input and output sides never open together
    p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R2: a full section blocks further input
    p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt_q >= CNT_W'(CELLS)) |-> !in_ready);

    // R3: a section never drains more than its largest beat count
    p_beat_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_cnt_q <= CNT_W'(CELLS * STREAMS_MAX));

    // R5: a stalled value is held
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_soft)));

    // R7: the end of a drain reopens the input
    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> in_ready);

endmodule

bind bdi_section_buffer bdi_checker #(
    .CELLS       (CELLS),
    .STREAMS_MAX (STREAMS_MAX),
    .SW          (SW)
) u_bdi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_soft  (out_soft)
);

// File: tb/tb_bdi_section_buffer.sv
module tb_bdi_section_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int NCELLS     = 126;
    localparam int SWID       = 6;
    localparam int CWID       = 36;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [CWID-1:0] in_cell = '0;
    logic [1:0]      in_mode = 2'd0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [SWID-1:0] out_soft;

    int checks = 0;
    int failures = 0;
    logic [CWID-1:0] cells [NCELLS];
    int shifts [6] = '{0, 63, 105, 42, 21, 84};

    always #(CLK_PERIOD/2) clk = ~clk;

    bdi_section_buffer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_cell   (in_cell),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_soft  (out_soft)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int n_of(input logic [1:0] m);
        return (m == 2'd0) ? 2 : (m == 2'd1) ? 4 : 6;
    endfunction

    function automatic int expect_val(input int beat, input int n);
        int w = beat / n;
        int e = beat % n;
        int a = (w + shifts[e]) % NCELLS;
        return int'(cells[a][e*SWID +: SWID]);
    endfunction

    // One section: fill with gaps, change code after cell 0 (R6), drain with random ready.
    task automatic run_section(input logic [1:0] mode, input logic [1:0] alt, input int gap_pct);
        int idx = 0;
        int n = n_of(mode);
        int total = n * NCELLS;
        int beat = 0;
        bit prev_stall = 0;
        logic [SWID-1:0] prev_val = '0;
        for (int i = 0; i < NCELLS; i++) cells[i] = CWID'({$urandom(), $urandom()});
        while (idx < NCELLS) begin
            @(negedge clk);
            chk(in_ready && !out_valid, "R2 fill open", int'(in_ready), 1);
            in_valid = (($urandom() % 100) >= gap_pct);
            in_cell  = cells[idx];
            in_mode  = (idx == 0) ? mode : alt;
            if (in_valid && in_ready) idx++;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_cell  = '1;
        chk(!in_ready && out_valid, "R2 stall after 126", int'(in_ready), 0);
        while (beat < total) begin
            chk(!in_ready, "R2 stall while draining", int'(in_ready), 0);
            chk(out_valid, "R3 valid before all beats", int'(out_valid), 1);
            if (prev_stall) chk(out_soft == prev_val, "R5 hold", int'(out_soft), int'(prev_val));
            out_ready = (($urandom() % 4) != 0);
            if (out_valid && out_ready) begin
                chk(int'(out_soft) == expect_val(beat, n), "R4 order", int'(out_soft),
                    expect_val(beat, n));
                beat++;
            end
            prev_stall = out_valid && !out_ready;
            prev_val   = out_soft;
            @(negedge clk);
        end
        chk(!out_valid, "R3 beat count", int'(out_valid), 0);
        chk(in_ready, "R7 reopen", int'(in_ready), 1);
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready, "R1 ready after reset", int'(in_ready), 1);
        chk(!out_valid, "R1 valid after reset", int'(out_valid), 0);
        run_section(2'd0, 2'd2, 0);    // R6: 2 streams, code jumps to 6
        run_section(2'd1, 2'd0, 30);   // R6: 4 streams, code drops to 2
        run_section(2'd2, 2'd1, 10);
        run_section(2'd3, 2'd0, 50);   // R3: code 3 acts as 6 streams
        for (int s = 0; s < 4; s++) begin
            logic [1:0] m = 2'($urandom() % 4);
            run_section(m, 2'($urandom() % 4), int'($urandom() % 60));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule